// File: doc/BRIEF.md
# Status Flag Register and Bit Transfer Unit

This block owns the eight processor condition flags and carries out the single-cycle instructions that set or clear one flag, or move one bit between a general register operand and the transfer flag. A 3-bit index picks the flag or operand bit. The execute stage presents an operation code, the index and the register operand. The unit then either updates the flag register on the next clock edge or returns a patched copy of the operand in the same cycle. That copy is written back to the register file.

The arithmetic unit updates flags through a separate port. That port has one write-enable per flag and one value per flag. When an instruction and the arithmetic port target the same flag in one cycle, the instruction wins on that flag. The arithmetic port still updates every flag that the instruction does not own. The interrupt enable flag is also driven onto a dedicated output for the interrupt controller.

Top module: `sreg_unit`

## Requirements
- R1: With `op_i` = 1 (flag set), the flag at index `idx_i` reads 1 in `sreg_o` after the next rising clock edge.
- R2: With `op_i` = 2 (flag clear), the flag at index `idx_i` reads 0 in `sreg_o` after the next rising clock edge.
- R3: A flag set or clear changes only its selected bit when the arithmetic port is idle. This covers the named flags carry (index 0), zero (1), negative (2), signed (4) and interrupt enable (7).
- R4: With `op_i` = 3 (transfer store), bit `idx_i` of `opnd_i` is copied into the transfer flag (bit 6) at the next rising edge.
- R5: With `op_i` = 4 (transfer load), `res_o` equals `opnd_i` with bit `idx_i` replaced by the transfer flag. The result appears in the same cycle, and no flag changes if the arithmetic port is idle.
- R6: For any `op_i` other than 4, `res_o` equals `opnd_i`.
- R7: Flag positions from bit 7 down to bit 0 are interrupt enable, transfer, half carry, signed, overflow, negative, zero and carry. `irq_en_o` always equals bit 7 of `sreg_o`.
- R8: With `op_i` = 0, each flag whose `alu_we_i` bit is 1 takes the matching `alu_flags_i` bit at the next edge. All other flags hold.
- R9: In a cycle where an instruction writes a flag and the arithmetic port also writes that flag, the instruction's value is stored. The arithmetic port still updates the flags the instruction does not write.
- R10: Op codes 5 to 7 act as no operation.
- R11: While `rst_n` is low, `sreg_o` is 0x00 and instructions are ignored. Release is synchronised: instructions take effect only from the third rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation: 0 none, 1 flag set, 2 flag clear, 3 transfer store, 4 transfer load |
| idx_i | input | 3 | Flag index or operand bit index |
| opnd_i | input | 8 | Register operand |
| alu_we_i | input | 8 | Per-flag write enables from the arithmetic unit |
| alu_flags_i | input | 8 | Flag values from the arithmetic unit |
| sreg_o | output | 8 | Current flag register |
| res_o | output | 8 | Register byte to write back (patched on transfer load) |
| irq_en_o | output | 1 | Global interrupt enable flag |

## Verification
Flag-changing results (set, clear, transfer store and arithmetic updates) are due one rising edge after the stimulus. The bench drives each input on a falling edge and reads `sreg_o` on the following falling edge, after exactly one rising edge has passed. The transfer-load result is combinational, so `res_o` is read a nanosecond after the inputs settle, before any rising edge. The flags are read again one edge later to confirm nothing moved. Reset checks count two rising edges of synchroniser latency after release before expecting any instruction to act.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int SREG_W = 8;
  localparam int IDX_W  = $clog2(SREG_W);

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_FSET   = 3'd1,
    OP_FCLR   = 3'd2,
    OP_TSTORE = 3'd3,
    OP_TLOAD  = 3'd4
  } sreg_op_e;

  localparam int POS_C = 0;
  localparam int POS_Z = 1;
  localparam int POS_N = 2;
  localparam int POS_V = 3;
  localparam int POS_S = 4;
  localparam int POS_H = 5;
  localparam int POS_T = 6;
  localparam int POS_I = 7;
endpackage

// File: rtl/sreg_rst_sync.sv
module sreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sreg_opdec.sv
module sreg_opdec
  import sreg_pkg::*;
#(
  parameter int W  = SREG_W,
  parameter int IW = IDX_W
) (
  input  logic [2:0]    op_i,
  input  logic [IW-1:0] idx_i,
  input  logic [W-1:0]  opnd_i,
  output logic [W-1:0]  ins_mask_o,
  output logic [W-1:0]  ins_val_o,
  output logic          is_tload_o
);
  sreg_op_e op;
  logic [W-1:0] idx_hot;
  logic         store_bit;

  assign op = sreg_op_e'(op_i);

  for (genvar g = 0; g < W; g++) begin : g_hot
    assign idx_hot[g] = (idx_i == IW'(g));
  end

  assign store_bit = opnd_i[idx_i];

  always_comb begin
    ins_mask_o = '0;
    ins_val_o  = '0;
    is_tload_o = 1'b0;
    case (op)
      OP_FSET: begin
        ins_mask_o = idx_hot;
        ins_val_o  = idx_hot;
      end
      OP_FCLR: begin
        ins_mask_o = idx_hot;
        ins_val_o  = '0;
      end
      OP_TSTORE: begin
        ins_mask_o[POS_T] = 1'b1;
        ins_val_o[POS_T]  = store_bit;
      end
      OP_TLOAD: is_tload_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sreg_next.sv
module sreg_next
  import sreg_pkg::*;
#(
  parameter int W = SREG_W
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] ins_mask_i,
  input  logic [W-1:0] ins_val_i,
  input  logic [W-1:0] alu_we_i,
  input  logic [W-1:0] alu_val_i,
  output logic [W-1:0] nxt_o,
  output logic         upd_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_comb begin
      if (ins_mask_i[g])     nxt_o[g] = ins_val_i[g];
      else if (alu_we_i[g])  nxt_o[g] = alu_val_i[g];
      else                   nxt_o[g] = cur_i[g];
    end
  end

  assign upd_o = |(ins_mask_i | alu_we_i);
endmodule

// File: rtl/sreg_bitload.sv
module sreg_bitload
  import sreg_pkg::*;
#(
  parameter int W  = SREG_W,
  parameter int IW = IDX_W
) (
  input  logic          en_i,
  input  logic [IW-1:0] idx_i,
  input  logic [W-1:0]  opnd_i,
  input  logic          t_i,
  output logic [W-1:0]  res_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign res_o[g] = (en_i && idx_i == IW'(g)) ? t_i : opnd_i[g];
  end

  always_comb begin
    if (en_i) begin
      p_tload_bit_r5: assert (res_o[idx_i] == t_i);
    end else begin
      p_passthru_r6: assert (res_o == opnd_i);
    end
  end
endmodule

// File: rtl/sreg_unit.sv
module sreg_unit
  import sreg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          op_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [SREG_W-1:0]   opnd_i,
  input  logic [SREG_W-1:0]   alu_we_i,
  input  logic [SREG_W-1:0]   alu_flags_i,
  output logic [SREG_W-1:0]   sreg_o,
  output logic [SREG_W-1:0]   res_o,
  output logic                irq_en_o
);
  logic              rst_sync_n;
  logic [SREG_W-1:0] sreg_q;
  logic [SREG_W-1:0] sreg_d;
  logic [SREG_W-1:0] ins_mask;
  logic [SREG_W-1:0] ins_val;
  logic [SREG_W-1:0] ins_mask_g;
  logic              is_tload;
  logic              upd_en;

  sreg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sreg_opdec #(.W(SREG_W), .IW(IDX_W)) u_dec (
    .op_i       (op_i),
    .idx_i      (idx_i),
    .opnd_i     (opnd_i),
    .ins_mask_o (ins_mask),
    .ins_val_o  (ins_val),
    .is_tload_o (is_tload)
  );

  assign ins_mask_g = rst_sync_n ? ins_mask : '0;

  sreg_next #(.W(SREG_W)) u_nxt (
    .cur_i      (sreg_q),
    .ins_mask_i (ins_mask_g),
    .ins_val_i  (ins_val),
    .alu_we_i   (alu_we_i),
    .alu_val_i  (alu_flags_i),
    .nxt_o      (sreg_d),
    .upd_o      (upd_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sreg_q <= '0;
    else if (upd_en)  sreg_q <= sreg_d;
  end

  sreg_bitload #(.W(SREG_W), .IW(IDX_W)) u_bl (
    .en_i   (is_tload),
    .idx_i  (idx_i),
    .opnd_i (opnd_i),
    .t_i    (sreg_q[POS_T]),
    .res_o  (res_o)
  );

  assign sreg_o   = sreg_q;
  assign irq_en_o = sreg_q[POS_I];

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd1) |=> sreg_o[$past(idx_i)]);

  p_clr_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd2) |=> !sreg_o[$past(idx_i)]);

  p_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((op_i == 3'd1 || op_i == 3'd2) && alu_we_i == '0)
      |=> $countones(sreg_o ^ $past(sreg_o)) <= 1);

  p_tstore_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd3) |=> sreg_o[POS_T] == $past(opnd_i[idx_i]));

  p_tload_flags_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd4 && alu_we_i == '0) |=> $stable(sreg_o));

  p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i > 3'd4 && alu_we_i == '0) |=> $stable(sreg_o));

  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_en_o == sreg_o[POS_I]);

  p_alu_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == 3'd0) |=> sreg_o == (($past(alu_we_i) & $past(alu_flags_i))
                                 | (~$past(alu_we_i) & $past(sreg_o))));
endmodule

// File: tb/tb_sreg_unit.sv
module tb_sreg_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_i;
  logic [2:0] idx_i;
  logic [7:0] opnd_i;
  logic [7:0] alu_we_i;
  logic [7:0] alu_flags_i;
  logic [7:0] sreg_o;
  logic [7:0] res_o;
  logic       irq_en_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_s;

  always #5 clk = ~clk;

  sreg_unit dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i), .opnd_i(opnd_i),
    .alu_we_i(alu_we_i), .alu_flags_i(alu_flags_i),
    .sreg_o(sreg_o), .res_o(res_o), .irq_en_o(irq_en_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [2:0] idx, input logic [7:0] opnd,
                       input logic [7:0] we, input logic [7:0] fl);
    op_i = op; idx_i = idx; opnd_i = opnd; alu_we_i = we; alu_flags_i = fl;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
    drive(3'd0, 3'd0, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive(3'd1, 3'd7, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    chk("R11 reset value", sreg_o, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R11 ignored during sync edge 1", sreg_o, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R11 ignored during sync edge 2", sreg_o, 8'h00);
    drive(3'd0, 3'd0, 8'h00, 8'h00, 8'h00);
    step();
    chk("R11 idle after release", sreg_o, 8'h00);
    exp_s = 8'h00;
  endtask

  task automatic t_set_all;
    for (int i = 0; i < 8; i++) begin
      drive(3'd1, 3'(i), 8'h00, 8'h00, 8'h00);
      step();
      exp_s[i] = 1'b1;
      chk("R1 flag set by index", sreg_o, exp_s);
    end
    chk("R7 irq_en_o follows bit 7", {7'd0, irq_en_o}, 8'h01);
  endtask

  task automatic t_clr_all;
    for (int i = 7; i >= 0; i--) begin
      drive(3'd2, 3'(i), 8'h00, 8'h00, 8'h00);
      step();
      exp_s[i] = 1'b0;
      chk("R2 flag clear by index", sreg_o, exp_s);
    end
    chk("R7 irq_en_o low after clear", {7'd0, irq_en_o}, 8'h00);
  endtask

  task automatic t_shortcuts;
    int named [5] = '{0, 1, 2, 4, 7};
    exp_s = 8'h00;
    for (int k = 0; k < 5; k++) begin
      drive(3'd1, 3'(named[k]), 8'hFF, 8'h00, 8'h00);
      step();
      chk("R3 named set touches own bit only", sreg_o, 8'h01 << named[k]);
      drive(3'd2, 3'(named[k]), 8'hFF, 8'h00, 8'h00);
      step();
      chk("R3 named clear touches own bit only", sreg_o, 8'h00);
    end
    drive(3'd0, 3'd0, 8'h00, 8'hFF, 8'hFF);
    step();
    drive(3'd2, 3'd4, 8'h00, 8'h00, 8'h00);
    step();
    chk("R3 clear signed among all-ones", sreg_o, 8'hEF);
    exp_s = 8'hEF;
  endtask

  task automatic t_tstore;
    drive(3'd3, 3'd5, 8'h20, 8'h00, 8'h00);
    step();
    exp_s[6] = 1'b1;
    chk("R4 store bit 5 = 1 into T", sreg_o, exp_s);
    drive(3'd3, 3'd2, 8'hFB, 8'h00, 8'h00);
    step();
    exp_s[6] = 1'b0;
    chk("R4 store bit 2 = 0 into T", sreg_o, exp_s);
    drive(3'd3, 3'd0, 8'h01, 8'h00, 8'h00);
    step();
    exp_s[6] = 1'b1;
    chk("R4 store bit 0 = 1 into T", sreg_o, exp_s);
  endtask

  task automatic t_tload;
    drive(3'd4, 3'd3, 8'h00, 8'h00, 8'h00);
    #1;
    chk("R5 load T=1 into bit 3 same cycle", res_o, 8'h08);
    step();
    chk("R5 flags unchanged by load", sreg_o, exp_s);
    drive(3'd2, 3'd6, 8'h00, 8'h00, 8'h00);
    step();
    exp_s[6] = 1'b0;
    drive(3'd4, 3'd7, 8'hFF, 8'h00, 8'h00);
    #1;
    chk("R5 load T=0 into bit 7", res_o, 8'h7F);
    step();
    chk("R5 flags unchanged by second load", sreg_o, exp_s);
    drive(3'd1, 3'd1, 8'hA5, 8'h00, 8'h00);
    #1;
    chk("R6 res passthru on set", res_o, 8'hA5);
    step();
    exp_s[1] = 1'b1;
    drive(3'd3, 3'd1, 8'h5A, 8'h00, 8'h00);
    #1;
    chk("R6 res passthru on store", res_o, 8'h5A);
    step();
    exp_s[6] = 1'b1;
    chk("R4 store during passthru", sreg_o, exp_s);
  endtask

  task automatic t_alu;
    drive(3'd0, 3'd0, 8'h00, 8'h0F, 8'h05);
    step();
    exp_s = (exp_s & 8'hF0) | 8'h05;
    chk("R8 alu mask low nibble", sreg_o, exp_s);
    drive(3'd0, 3'd0, 8'h00, 8'h3C, 8'h00);
    step();
    exp_s = exp_s & ~8'h3C;
    chk("R8 alu mask middle bits", sreg_o, exp_s);
    drive(3'd0, 3'd0, 8'h00, 8'h00, 8'hFF);
    step();
    chk("R8 no enable no change", sreg_o, exp_s);
  endtask

  task automatic t_prio;
    drive(3'd0, 3'd0, 8'h00, 8'hFF, 8'h00);
    step();
    drive(3'd1, 3'd3, 8'h00, 8'hFF, 8'h80);
    step();
    chk("R9 set wins on same flag, alu on rest", sreg_o, 8'h88);
    drive(3'd2, 3'd7, 8'h00, 8'hFF, 8'hFF);
    step();
    chk("R9 clear wins over alu", sreg_o, 8'h7F);
    drive(3'd3, 3'd4, 8'h00, 8'hFF, 8'hFF);
    step();
    chk("R9 store wins on T", sreg_o, 8'hBF);
    exp_s = 8'hBF;
  endtask

  task automatic t_reserved;
    for (int o = 5; o < 8; o++) begin
      drive(3'(o), 3'(o), 8'h3C, 8'h00, 8'h00);
      #1;
      chk("R10 reserved op res passthru", res_o, 8'h3C);
      step();
      chk("R10 reserved op leaves flags", sreg_o, exp_s);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(3'd0, 3'd0, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    t_reset();
    t_set_all();
    t_clr_all();
    t_shortcuts();
    t_tstore();
    t_tload();
    t_alu();
    t_prio();
    t_reserved();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule